// File: doc/BRIEF.md
# Special-Mode Effective Address Generator

This block forms the 20-bit effective address used by a small controller's wide-range addressing modes. Three modes are supported: a direct 20-bit address taken from the instruction's immediate field, a base-plus-offset mode that adds an unsigned 16-bit address register to a 20-bit offset, and a register-pair mode that joins the two 16-bit address registers into one wide pointer. Each mode is allowed only with certain instruction classes. A disallowed pairing does not produce an address. Instead it raises an error flag, and the address output reads zero.

Requests enter on a valid/ready input and results leave on a valid/ready output through one register stage. A request is taken on any rising edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty, or when its contents are being taken in the same cycle (`out_ready` high). While `out_valid` is high and `out_ready` is low, the output holds its address and flag unchanged and no new request is taken. Upstream must keep its request steady until it sees `in_ready`.

Top module: `far_ea_gen`

## Requirements
- R1: With mode code 2'b00 (direct), the result address equals `in_imm`, full range 0x00000 to 0xFFFFF, and is legal for all four class codes.
- R2: With mode code 2'b01 (base-plus-offset), the result is `in_imm` plus the chosen register, read as unsigned with no sign extension. `in_base_sel`=0 chooses `in_a0` and 1 chooses `in_a1`. Bits above bit 19 of the sum are dropped, so the address wraps past 0xFFFFF to 0x00000.
- R3: Base-plus-offset with `in_a0` is legal for every class. With `in_a1` it is legal only for class codes 2'b10 (far jump) and 2'b11 (far call), and illegal for 2'b00 (wide load) and 2'b01 (wide store).
- R4: With mode code 2'b10 (register pair), the 32-bit value {`in_a1`,`in_a0`} is formed and its low 20 bits are the result. This mode is legal only for class codes 2'b00 and 2'b01.
- R5: Mode code 2'b11 is reserved and illegal for every class.
- R6: An illegal pairing sets `out_err`=1 and `out_addr`=0 for that result. A legal pairing gives `out_err`=0.
- R7: `in_ready` = !`out_valid` || `out_ready`. A request taken at a rising edge appears on `out_addr`/`out_err` with `out_valid`=1 right after that edge.
- R8: While `out_valid`=1 and `out_ready`=0, `out_addr`, `out_err` and `out_valid` stay unchanged, and input changes have no effect on them.
- R9: During and after reset, `out_valid`=0, `out_err`=0 and `out_addr`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| in_mode | input | 2 | 00 direct, 01 base-plus-offset, 10 register pair, 11 reserved |
| in_cls | input | 2 | 00 wide load, 01 wide store, 10 far jump, 11 far call |
| in_base_sel | input | 1 | Base register for mode 01: 0 = A0, 1 = A1 |
| in_imm | input | 20 | Direct address or offset |
| in_a0 | input | 16 | Address register A0 |
| in_a1 | input | 16 | Address register A1 |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Downstream takes the result |
| out_addr | output | 20 | Effective address, zero when illegal |
| out_err | output | 1 | Illegal mode/class pairing |

## Verification
Every result is due exactly one rising edge after the edge that takes the request. The bench therefore drives each request at a falling edge, waits for the next rising edge, and reads `out_valid`, `out_addr` and `out_err` one nanosecond later. `in_ready` is combinational, so it is read between edges in the same cycle that `out_ready` is changed. The stall checks hold `out_ready` low across several edges while the inputs change. They confirm that the outputs are unchanged at each of those edges, and that the waiting request appears one edge after `out_ready` is raised.

// File: rtl/far_ea_pkg.sv
package far_ea_pkg;
  parameter int AW = 20;
  parameter int RW = 16;

  typedef enum logic [1:0] {
    MD_DIRECT = 2'b00,
    MD_OFFSET = 2'b01,
    MD_PAIR   = 2'b10,
    MD_RSVD   = 2'b11
  } ea_mode_e;

  typedef enum logic [1:0] {
    CL_WLOAD  = 2'b00,
    CL_WSTORE = 2'b01,
    CL_FJUMP  = 2'b10,
    CL_FCALL  = 2'b11
  } ea_cls_e;

  typedef struct packed {
    logic [AW-1:0] addr;
    logic          err;
  } ea_res_t;
endpackage

// File: rtl/far_ea_legal.sv
module far_ea_legal
  import far_ea_pkg::*;
(
  input  logic [1:0] mode,
  input  logic [1:0] cls,
  input  logic       base_sel,
  output logic       legal
);
  logic is_xfer;   // far jump or far call
  assign is_xfer = cls[1];

  always_comb begin
    unique case (ea_mode_e'(mode))
      MD_DIRECT: legal = 1'b1;
      MD_OFFSET: legal = base_sel ? is_xfer : 1'b1;
      MD_PAIR:   legal = !is_xfer;
      default:   legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/far_ea_calc.sv
module far_ea_calc
  import far_ea_pkg::*;
#(
  parameter int P_AW = AW,
  parameter int P_RW = RW
) (
  input  logic [1:0]      mode,
  input  logic            base_sel,
  input  logic [P_AW-1:0] imm,
  input  logic [P_RW-1:0] a0,
  input  logic [P_RW-1:0] a1,
  output logic [P_AW-1:0] addr
);
  localparam int PW = 2 * P_RW;

  logic [P_RW-1:0] base;
  logic [P_AW-1:0] base_ext;
  logic [P_AW-1:0] offs_sum;
  logic [PW-1:0]   pair_val;

  assign base     = base_sel ? a1 : a0;
  assign base_ext = P_AW'(base);          // zero extension, no sign
  assign offs_sum = imm + base_ext;       // carry out of the top bit is dropped
  assign pair_val = {a1, a0};

  always_comb begin
    unique case (ea_mode_e'(mode))
      MD_DIRECT: addr = imm;
      MD_OFFSET: addr = offs_sum;
      MD_PAIR:   addr = pair_val[P_AW-1:0];
      default:   addr = '0;
    endcase
  end
endmodule

// File: rtl/far_ea_outreg.sv
module far_ea_outreg
  import far_ea_pkg::*;
#(
  parameter int P_AW = AW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            s_valid,
  output logic            s_ready,
  input  logic [P_AW-1:0] s_addr,
  input  logic            s_err,
  output logic            m_valid,
  input  logic            m_ready,
  output logic [P_AW-1:0] m_addr,
  output logic            m_err
);
  logic take;
  assign s_ready = !m_valid || m_ready;
  assign take    = s_valid && s_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_addr  <= '0;
      m_err   <= 1'b0;
    end else if (take) begin
      m_valid <= 1'b1;
      m_addr  <= s_addr;
      m_err   <= s_err;
    end else if (m_ready) begin
      m_valid <= 1'b0;
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_addr) && $stable(m_err))); // R8

  AST_TAKE_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> m_valid); // R7
endmodule

// File: rtl/far_ea_gen.sv
module far_ea_gen
  import far_ea_pkg::*;
#(
  parameter int P_AW = AW,
  parameter int P_RW = RW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [1:0]      in_mode,
  input  logic [1:0]      in_cls,
  input  logic            in_base_sel,
  input  logic [P_AW-1:0] in_imm,
  input  logic [P_RW-1:0] in_a0,
  input  logic [P_RW-1:0] in_a1,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [P_AW-1:0] out_addr,
  output logic            out_err
);
  localparam int PW = 2 * P_RW;

  logic            legal;
  logic [P_AW-1:0] raw_addr;
  logic [P_AW-1:0] res_addr;

  far_ea_legal u_legal (
    .mode     (in_mode),
    .cls      (in_cls),
    .base_sel (in_base_sel),
    .legal    (legal)
  );

  far_ea_calc #(.P_AW(P_AW), .P_RW(P_RW)) u_calc (
    .mode     (in_mode),
    .base_sel (in_base_sel),
    .imm      (in_imm),
    .a0       (in_a0),
    .a1       (in_a1),
    .addr     (raw_addr)
  );

  assign res_addr = legal ? raw_addr : '0;

  far_ea_outreg #(.P_AW(P_AW)) u_oreg (
    .clk     (clk),
    .rst_n   (rst_n),
    .s_valid (in_valid),
    .s_ready (in_ready),
    .s_addr  (res_addr),
    .s_err   (!legal),
    .m_valid (out_valid),
    .m_ready (out_ready),
    .m_addr  (out_addr),
    .m_err   (out_err)
  );

  logic acc;
  assign acc = in_valid && in_ready;

  AST_DIRECT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_mode == 2'b00) |=> (!out_err && out_addr == $past(in_imm))); // R1

  AST_PAIR_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_mode == 2'b10 && !in_cls[1]) |=>
      (!out_err && out_addr == $past(PW'({in_a1, in_a0}) & PW'({P_AW{1'b1}})))); // R4

  AST_RSVD_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_mode == 2'b11) |=> out_err); // R5

  AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_err) |-> (out_addr == '0)); // R6

  AST_A1_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_mode == 2'b01 && in_base_sel && !in_cls[1]) |=> out_err); // R3
endmodule

// File: tb/sim_far_ea_gen.sv
`timescale 1ns/1ps
module sim_far_ea_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_mode = 2'b00;
  logic [1:0]  in_cls = 2'b00;
  logic        in_base_sel = 1'b0;
  logic [19:0] in_imm = '0;
  logic [15:0] in_a0 = '0;
  logic [15:0] in_a1 = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [19:0] out_addr;
  logic        out_err;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  far_ea_gen u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_mode(in_mode), .in_cls(in_cls), .in_base_sel(in_base_sel),
    .in_imm(in_imm), .in_a0(in_a0), .in_a1(in_a1),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_addr(out_addr), .out_err(out_err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] m, input logic [1:0] c, input logic bs,
                       input logic [19:0] imm, input logic [15:0] a0, input logic [15:0] a1);
    in_mode = m; in_cls = c; in_base_sel = bs; in_imm = imm; in_a0 = a0; in_a1 = a1;
  endtask

  // one request, drained immediately; result checked one edge after acceptance
  task automatic send(input string tag, input logic [1:0] m, input logic [1:0] c,
                      input logic bs, input logic [19:0] imm, input logic [15:0] a0,
                      input logic [15:0] a1, input logic [19:0] exp_addr, input logic exp_err);
    @(negedge clk);
    out_ready = 1'b1;
    drive(m, c, bs, imm, a0, a1);
    in_valid = 1'b1;
    @(posedge clk); #1;
    chk({tag, " valid"}, {31'd0, out_valid}, 32'd1);
    chk({tag, " addr"}, {12'd0, out_addr}, {12'd0, exp_addr});
    chk({tag, " err"}, {31'd0, out_err}, {31'd0, exp_err});
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset();
    #1;
    chk("R9 valid in reset", {31'd0, out_valid}, 32'd0);
    chk("R9 err in reset", {31'd0, out_err}, 32'd0);
    chk("R9 addr in reset", {12'd0, out_addr}, 32'd0);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R9 valid after reset", {31'd0, out_valid}, 32'd0);
    chk("R7 ready when empty", {31'd0, in_ready}, 32'd1);
  endtask

  task automatic t_direct();
    send("R1 direct load max", 2'b00, 2'b00, 1'b0, 20'hFFFFF, 16'h1111, 16'h2222, 20'hFFFFF, 1'b0);
    send("R1 direct call",     2'b00, 2'b11, 1'b1, 20'h12345, 16'h0, 16'h0, 20'h12345, 1'b0);
    send("R1 direct store 0",  2'b00, 2'b01, 1'b0, 20'h00000, 16'hFFFF, 16'hFFFF, 20'h00000, 1'b0);
    send("R1 direct jump",     2'b00, 2'b10, 1'b0, 20'hA5A5A, 16'h0, 16'h0, 20'hA5A5A, 1'b0);
  endtask

  task automatic t_offset();
    send("R2 A0 unsigned",    2'b01, 2'b00, 1'b0, 20'h10000, 16'h8000, 16'h0001, 20'h18000, 1'b0);
    send("R2 A0 store",       2'b01, 2'b01, 1'b0, 20'h00F00, 16'h0123, 16'hFFFF, 20'h01023, 1'b0);
    send("R2 wrap A1 jump",   2'b01, 2'b10, 1'b1, 20'hFFFF0, 16'h0000, 16'h0020, 20'h00010, 1'b0);
    send("R2 edge A0 call",   2'b01, 2'b11, 1'b0, 20'hF0000, 16'hFFFF, 16'h0, 20'hFFFFF, 1'b0);
    send("R3 A1 call legal",  2'b01, 2'b11, 1'b1, 20'h00100, 16'h9999, 16'h0010, 20'h00110, 1'b0);
    send("R3 A1 load illegal",  2'b01, 2'b00, 1'b1, 20'h00100, 16'h0, 16'h0010, 20'h00000, 1'b1);
    send("R3 A1 store illegal", 2'b01, 2'b01, 1'b1, 20'h55555, 16'h0, 16'h1234, 20'h00000, 1'b1);
  endtask

  task automatic t_pair();
    send("R4 pair load",        2'b10, 2'b00, 1'b0, 20'h0, 16'h1234, 16'hABCD, 20'hD1234, 1'b0);
    send("R4 pair store",       2'b10, 2'b01, 1'b1, 20'hFFFFF, 16'hFFFF, 16'hFFF0, 20'h0FFFF, 1'b0);
    send("R4 R6 pair jump bad", 2'b10, 2'b10, 1'b0, 20'h0, 16'h1234, 16'hABCD, 20'h00000, 1'b1);
    send("R4 R6 pair call bad", 2'b10, 2'b11, 1'b0, 20'h0, 16'h1234, 16'hABCD, 20'h00000, 1'b1);
  endtask

  task automatic t_rsvd();
    for (int c = 0; c < 4; c++)
      send("R5 R6 reserved mode", 2'b11, 2'(c), 1'b0, 20'h3C3C3, 16'h5A5A, 16'hA5A5, 20'h00000, 1'b1);
  endtask

  task automatic t_stall();
    @(negedge clk);
    out_ready = 1'b0;
    drive(2'b00, 2'b00, 1'b0, 20'h0BEEF, 16'h0, 16'h0);
    in_valid = 1'b1;
    @(posedge clk); #1;
    chk("R7 stall first valid", {31'd0, out_valid}, 32'd1);
    chk("R7 stall first addr", {12'd0, out_addr}, 32'h0BEEF);
    chk("R7 ready low when full", {31'd0, in_ready}, 32'd0);
    @(negedge clk);
    drive(2'b11, 2'b00, 1'b0, 20'h77777, 16'h0, 16'h0);  // illegal, must wait
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #1;
      chk("R8 hold valid", {31'd0, out_valid}, 32'd1);
      chk("R8 hold addr", {12'd0, out_addr}, 32'h0BEEF);
      chk("R8 hold err", {31'd0, out_err}, 32'd0);
    end
    @(negedge clk);
    out_ready = 1'b1;
    #1;
    chk("R7 ready while draining", {31'd0, in_ready}, 32'd1);
    @(posedge clk); #1;
    chk("R7 waiting request taken", {31'd0, out_valid}, 32'd1);
    chk("R7 waiting request err", {31'd0, out_err}, 32'd1);
    chk("R6 waiting request addr", {12'd0, out_addr}, 32'd0);
    @(negedge clk);
    in_valid = 1'b0;
    @(posedge clk); #1;
    chk("R7 drained", {31'd0, out_valid}, 32'd0);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_direct();
        t_offset();
        t_pair();
        t_rsvd();
        t_stall();
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule